// File: doc/BRIEF.md
# Link Capability Resolver

This block decides the operating speed and duplex of a 10/100 Ethernet MAC. It takes two 16-bit words that have already been read from the PHY: the local advertisement and the link-partner ability. It ANDs them to find the abilities both ends share, then picks the best common mode by a fixed priority. If no common mode exists, it falls back to 10 Mb/s half duplex and flags the fallback.

The chosen mode is held in a small register. It is presented as a link-speed word, with a force flag and a decimal speed code, and as a duplex output. When the new mode really differs from the held one, the block emits a one-cycle change pulse, so that downstream MAC logic reprograms itself only when it has to. A caller presents both words with a one-cycle valid strobe whenever it has fresh values, for example after auto-negotiation or on a link event.

Top module: `link_mode_resolver`

## Requirements
- R1: The common ability is the bitwise AND of `local_adv` and `partner_abil`. An ability counts only when it is set in both words.
- R2: Within the common ability, bit 5 means 10 Mb/s half, bit 6 means 10 Mb/s full, bit 7 means 100 Mb/s half and bit 8 means 100 Mb/s full. The selection takes the highest of these in the order 100 full, 100 half, 10 full, 10 half.
- R3: When none of bits 5 to 8 is common, the result is 10 Mb/s half duplex and `bad_ability` is 1 for that result.
- R4: `link_word` has bit 16 (force) set to 1 and carries the decimal speed code in bits 15:0 (10 = 0x000A, 100 = 0x0064). All other bits are 0. `full_duplex` is 1 for full duplex.
- R5: After synchronous reset (`rst_n` low at a rising edge), `link_word` is 0x0001000A, `full_duplex` is 0, and `changed` and `bad_ability` are 0.
- R6: A result appears on `link_word` and `full_duplex` one clock after the edge at which `in_valid` is sampled high. Without a strobe, these outputs hold their value. Strobes may come on consecutive cycles.
- R7: `changed` is 1 for exactly the one cycle in which a new result is shown, and only if its speed or duplex differs from the previously held result. Otherwise it is 0.
- R8: Bits of the two input words outside bits 5 to 8 have no effect on any output.
- R9: `bad_ability` is a single-cycle pulse. It is 0 on every cycle that does not follow a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | One-cycle strobe: both ability words are valid |
| local_adv | input | 16 | Local advertisement word from the PHY |
| partner_abil | input | 16 | Link-partner ability word from the PHY |
| link_word | output | 32 | Encoded link speed: force flag at bit 16, decimal speed in bits 15:0 |
| full_duplex | output | 1 | 1 = full duplex, 0 = half duplex |
| changed | output | 1 | One-cycle pulse: the resolved speed or duplex differs from before |
| bad_ability | output | 1 | One-cycle pulse: no common ability, fallback was taken |

## Verification
The properties assume that `in_valid` is the only thing that can alter the held mode. They also assume that the ability words matter only in the cycle where the strobe is high, so the words may take any value while the strobe is low.

The stimulus follows that rule:
- It drives the words only together with the strobe.
- It mixes single strobes and idle gaps with runs of back-to-back strobes, so that both the hold behaviour and the change detection across consecutive results are covered.
- It fills the bits outside the ability field with values that would select a different mode if they were decoded.

// File: rtl/lmr_pkg.sv
// Package: shared constants and types for the link capability resolver.
// Assumes ability bits occupy a contiguous field whose index order equals
// the selection priority (index 0 lowest, highest index wins).
package lmr_pkg;
    localparam int ABIL_W    = 16;   // width of each PHY ability word
    localparam int ABIL_LSB  = 5;    // first ability bit in the word
    localparam int N_MODES   = 4;    // number of ability bits considered
    localparam int LINK_W    = 32;   // width of the encoded link word
    localparam int FORCE_POS = 16;   // position of the force flag
    localparam int CODE_W    = 16;   // width of the decimal speed code
    localparam int SPD_SLOW  = 10;   // decimal code for 10 Mb/s
    localparam int SPD_FAST  = 100;  // decimal code for 100 Mb/s

    // Mode index equals ability-field index; value order is priority order
    typedef enum logic [1:0] {
        MODE_10_HALF  = 2'd0,
        MODE_10_FULL  = 2'd1,
        MODE_100_HALF = 2'd2,
        MODE_100_FULL = 2'd3
    } lmode_e;

    // Speed and duplex split of a resolved mode
    typedef struct packed {
        logic fast;
        logic full;
    } lmode_t;

    // Translate a mode into its speed/duplex pair
    function automatic lmode_t split_mode(lmode_e m);
        lmode_t r;
        r.fast = (m == MODE_100_HALF) || (m == MODE_100_FULL);
        r.full = (m == MODE_10_FULL)  || (m == MODE_100_FULL);
        return r;
    endfunction
endpackage

// File: rtl/lmr_common.sv
// Module: forms the ability field shared by both link ends.
// Assumes the field sits at LSB..LSB+N-1 of each word; the other bits are
// deliberately discarded here so nothing downstream can decode them.
module lmr_common #(
    parameter int W   = 16,
    parameter int LSB = 5,
    parameter int N   = 4
) (
    input  logic [W-1:0] adv,
    input  logic [W-1:0] abil,
    output logic [N-1:0] shared
);
    localparam int HI = LSB + N;

    logic [W-1:0] both;
    logic         unused_bits;

    // Bitwise intersection of the two words
    always_comb both = adv & abil;

    // Keep only the ability field
    always_comb shared = both[LSB +: N];

    // Bits outside the field are intentionally dropped
    generate
        if (HI < W) begin : g_top_bits
            assign unused_bits = ^{both[W-1:HI], both[LSB-1:0]};
        end else begin : g_no_top_bits
            assign unused_bits = ^both[LSB-1:0];
        end
    endgenerate
endmodule

// File: rtl/lmr_pick.sv
// Module: fixed-priority selection over the shared ability field.
// Assumes field index i corresponds to mode value i and that a higher
// index has higher priority; an empty field selects the fallback mode.
module lmr_pick
    import lmr_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] shared,
    output lmode_e       mode,
    output logic         none
);
    // Scan upward so the highest set index is the last to be written
    always_comb begin
        mode = MODE_10_HALF;
        for (int i = 0; i < N; i++) begin
            if (shared[i]) begin
                mode = lmode_e'(i[1:0]);
            end
        end
    end

    // Flag an empty intersection
    always_comb none = (shared == '0);
endmodule

// File: rtl/lmr_state.sv
// Module: holds the resolved mode, encodes it, and pulses change/fallback.
// Assumes load is a one-cycle strobe; the held mode moves only on load.
module lmr_state
    import lmr_pkg::*;
#(
    parameter int LW   = 32,
    parameter int FPOS = 16,
    parameter int CW   = 16,
    parameter int SLOW = 10,
    parameter int FAST = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  lmode_e        mode,
    input  logic          none,
    output logic [LW-1:0] link_word,
    output logic          full_duplex,
    output logic          changed,
    output logic          bad_ability
);
    localparam logic [CW-1:0] CODE_SLOW = CW'(SLOW);
    localparam logic [CW-1:0] CODE_FAST = CW'(FAST);

    lmode_t        nxt;
    logic          cur_fast;
    logic          cur_full;
    logic [LW-1:0] nxt_word;

    // Split the candidate mode into speed and duplex
    always_comb nxt = split_mode(mode);

    // Encode a speed flag into the link-word layout
    function automatic logic [LW-1:0] encode(logic fast);
        logic [LW-1:0] w;
        w           = '0;
        w[FPOS]     = 1'b1;
        w[CW-1:0]   = fast ? CODE_FAST : CODE_SLOW;
        return w;
    endfunction

    // Candidate word, used for the comparison against the held word
    always_comb nxt_word = encode(nxt.fast);

    // Held mode plus one-cycle change and fallback pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_fast    <= 1'b0;
            cur_full    <= 1'b0;
            changed     <= 1'b0;
            bad_ability <= 1'b0;
        end else begin
            changed     <= 1'b0;
            bad_ability <= 1'b0;
            if (load) begin
                cur_fast    <= nxt.fast;
                cur_full    <= nxt.full;
                changed     <= (nxt_word != link_word) || (nxt.full != cur_full);
                bad_ability <= none;
            end
        end
    end

    // Outputs derived from the held mode
    always_comb link_word   = encode(cur_fast);
    always_comb full_duplex = cur_full;
endmodule

// File: rtl/link_mode_resolver.sv
// Module: top of the link capability resolver.
// Intersects the local advertisement with the partner ability, picks the
// best common 10/100 mode by fixed priority, and holds the result.
// Assumes both words are valid only in a cycle where in_valid is high.
module link_mode_resolver
    import lmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ABIL_W-1:0] local_adv,
    input  logic [ABIL_W-1:0] partner_abil,
    output logic [LINK_W-1:0] link_word,
    output logic              full_duplex,
    output logic              changed,
    output logic              bad_ability
);
    logic [N_MODES-1:0] shared;
    lmode_e             pick_mode;
    logic               pick_none;

    // Common ability field
    lmr_common #(.W(ABIL_W), .LSB(ABIL_LSB), .N(N_MODES)) u_common (
        .adv    (local_adv),
        .abil   (partner_abil),
        .shared (shared)
    );

    // Priority choice
    lmr_pick #(.N(N_MODES)) u_pick (
        .shared (shared),
        .mode   (pick_mode),
        .none   (pick_none)
    );

    // Held state and encoding
    lmr_state #(
        .LW   (LINK_W),
        .FPOS (FORCE_POS),
        .CW   (CODE_W),
        .SLOW (SPD_SLOW),
        .FAST (SPD_FAST)
    ) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (in_valid),
        .mode        (pick_mode),
        .none        (pick_none),
        .link_word   (link_word),
        .full_duplex (full_duplex),
        .changed     (changed),
        .bad_ability (bad_ability)
    );
endmodule

// File: rtl/lmr_checks.sv
// Checker: temporal properties on the resolver's ports, bound to the top.
// Assumes the held mode may only move in the cycle after a strobe.
module lmr_checks
    import lmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [LINK_W-1:0] link_word,
    input logic              full_duplex,
    input logic              changed,
    input logic              bad_ability
);
    localparam logic [LINK_W-1:0] W_SLOW = LINK_W'((1 << FORCE_POS) | SPD_SLOW);
    localparam logic [LINK_W-1:0] W_FAST = LINK_W'((1 << FORCE_POS) | SPD_FAST);

    AST_WORD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (link_word == W_SLOW) || (link_word == W_FAST));  // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(link_word) && $stable(full_duplex)));  // R6

    AST_CHG_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        changed |-> $past(in_valid));  // R7

    AST_CHG_REAL: assert property (@(posedge clk) disable iff (!rst_n)
        changed |-> (!$stable(link_word) || !$stable(full_duplex)));  // R7

    AST_NOCHG_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && !changed) |-> ($stable(link_word) && $stable(full_duplex)));  // R7

    AST_BAD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_ability |-> $past(in_valid));  // R9

    AST_BAD_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        bad_ability |-> ((link_word == W_SLOW) && !full_duplex));  // R3
endmodule

bind link_mode_resolver lmr_checks u_checks (.*);

// File: tb/link_mode_resolver_bench.sv
// Bench: scoreboard; the driver queues expected results, the monitor compares.
module link_mode_resolver_bench;
    typedef struct {
        logic [31:0] word;
        logic        dup;
        logic        chg;
        logic        bad;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] adv = '0;
    logic [15:0] lpa = '0;
    logic [31:0] link_word;
    logic        full_duplex;
    logic        changed;
    logic        bad_ability;

    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;
    bit   seen = 1'b0;
    bit   armed = 1'b0;
    exp_t exp_q[$];

    // expected state held by the driver model
    logic [31:0] m_word = 32'h0001_000A;
    logic        m_dup  = 1'b0;
    // last result observed by the monitor
    logic [31:0] o_word = 32'h0001_000A;
    logic        o_dup  = 1'b0;

    link_mode_resolver u_link_mode_resolver (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .local_adv    (adv),
        .partner_abil (lpa),
        .link_word    (link_word),
        .full_duplex  (full_duplex),
        .changed      (changed),
        .bad_ability  (bad_ability)
    );

    always #10 clk = ~clk;

    always @(posedge clk) seen <= in_valid && rst_n;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: compute the expected result, queue it, then strobe the words.
    task automatic send(input logic [15:0] a, input logic [15:0] p, input string tag);
        exp_t        e;
        logic [15:0] c;
        logic        f;
        logic        d;
        c     = a & p;
        e.bad = 1'b0;
        if (c[8])      begin f = 1'b1; d = 1'b1; end
        else if (c[7]) begin f = 1'b1; d = 1'b0; end
        else if (c[6]) begin f = 1'b0; d = 1'b1; end
        else if (c[5]) begin f = 1'b0; d = 1'b0; end
        else           begin f = 1'b0; d = 1'b0; e.bad = 1'b1; end
        e.word = 32'h0001_0000 | (f ? 32'd100 : 32'd10);
        e.dup  = d;
        e.chg  = (e.word != m_word) || (d != m_dup);
        e.tag  = tag;
        m_word = e.word;
        m_dup  = d;
        exp_q.push_back(e);
        @(negedge clk);
        in_valid = 1'b1;
        adv      = a;
        lpa      = p;
    endtask

    // End a strobe run and stay idle; the words carry junk to show they are ignored.
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            adv      = 16'hFFFF;
            lpa      = 16'h0000 + 16'(k);
        end
    endtask

    // Monitor: at each falling edge, compare against the queue or check the hold.
    always @(negedge clk) begin
        if (armed && rst_n) begin
            if (seen) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "result without a queued item", 32'd0, 32'd1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(link_word == e.word, e.tag, "link_word", link_word, e.word);
                    chk(full_duplex == e.dup, e.tag, "full_duplex", 32'(full_duplex), 32'(e.dup));
                    chk(changed == e.chg, "R7", "changed", 32'(changed), 32'(e.chg));
                    chk(bad_ability == e.bad, "R3", "bad_ability", 32'(bad_ability), 32'(e.bad));
                    o_word = e.word;
                    o_dup  = e.dup;
                end
            end else begin
                chk(link_word == o_word && full_duplex == o_dup, "R6", "hold while idle",
                    {link_word[30:0], full_duplex}, {o_word[30:0], o_dup});
                chk(!changed, "R7", "changed while idle", 32'(changed), 32'd0);
                chk(!bad_ability, "R9", "bad_ability while idle", 32'(bad_ability), 32'd0);
            end
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(link_word == 32'h0001_000A, "R5", "reset link_word", link_word, 32'h0001_000A);
        chk(!full_duplex, "R5", "reset duplex", 32'(full_duplex), 32'd0);
        chk(!changed && !bad_ability, "R5", "reset pulses",
            {30'd0, changed, bad_ability}, 32'd0);
        armed = 1'b1;

        send(16'h01E1, 16'h01E1, "R2");   // all common: 100 full
        idle(2);
        send(16'h01E1, 16'h01E1, "R7");   // same again: no change
        idle(2);
        send(16'h01E1, 16'h00A0, "R2");   // bits 5,7: 100 half
        idle(1);
        send(16'h0061, 16'h01E1, "R2");   // bits 5,6: 10 full
        idle(1);
        send(16'h0020, 16'h0020, "R2");   // 10 half
        idle(1);
        send(16'h0100, 16'h0080, "R1");   // disjoint: fallback, no change
        idle(2);
        send(16'hFE1F, 16'hFE1F, "R8");   // only bits outside the field
        idle(1);
        send(16'hFFFF, 16'h0140, "R8");   // bits 6,8 with noise: 100 full
        idle(1);
        send(16'h001F, 16'hFFFF, "R3");   // fallback from 100 full: change + bad
        send(16'h0080, 16'h0080, "R6");   // back-to-back strobes
        send(16'h0080, 16'h0080, "R7");
        send(16'h0040, 16'h0040, "R6");
        idle(3);

        lf = 16'hACE1;
        for (int n = 0; n < 60; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            send(lf, {lf[7:0], lf[15:8]} ^ 16'h0155, "R2");
            if (n % 7 == 3) idle(1);
        end
        idle(4);
        chk(exp_q.size() == 0, "R6", "queue drained", 32'(exp_q.size()), 32'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R6 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule